// File: doc/BRIEF.md
# Distinct-Bias Oscillator Configuration Selector

This block chooses a bias setting for each of three noise oscillators so that no two oscillators share a bias. Its input is a table of entropy scores with one entry for each oscillator and each of four bias values. It reads that table through a simple read port with one cycle of latency. It then tries every assignment in which the three biases are pairwise different, evaluating one assignment per clock. The assignment with the largest summed score is kept.

When the search ends, the block raises a one-cycle done pulse. It then presents the packed bias word, the winning total, the score each oscillator contributes to that total, and a flag that reports when the winning total falls short of a minimum. From the chosen biases and an externally supplied accumulate count, it also forms four control words: one per oscillator, plus one that enables all three.

Top module: `osc_bias_selector`

## Requirements
- R1: After reset the bias word is 0x24 (oscillator n at bias n), the best total and all cell scores are zero, done is low, and the short-entropy flag is high.
- R2: A start pulse in idle triggers twelve table reads on consecutive cycles, at addresses 0 to 11 in order. The address is oscillator*4 + bias. The data for a read strobe is taken on the clock edge after the strobe.
- R3: The packed bias word holds oscillator n's bias in bits [2n+1:2n]. Only assignments whose three biases are pairwise distinct are ever reported.
- R4: The reported assignment has the largest three-score sum of all 24 distinct assignments. Candidates are ordered with oscillator 0's bias varying slowest and oscillator 2's fastest. On a tie, the earliest candidate in that order wins.
- R5: A candidate replaces the held best only if its sum is strictly greater than the held best. The held best starts at zero with the default 0x24 assignment, so an all-zero table reports 0x24 with a total of 0.
- R6: The best total output equals the winning sum. The cell score output carries each oscillator's score at its chosen bias, with oscillator n at bits [32n+31:32n] (32-bit scores).
- R7: The sum is kept two bits wider than a score, so three all-ones scores (32-bit) report 3*(2^32-1) exactly.
- R8: The short-entropy flag is high when the best total is below 150000000. It is low when the best total equals that value or exceeds it.
- R9: Each 22-bit control word has the select in bits [2:0], the bias in [4:3], the mode bit in [5] (always 1), and the accumulate count in [21:6]. For words n = 0..2 the select is 1<<n and the bias is oscillator n's. Word 3 has select 0x7 and bias 0.
- R10: Done is a single-cycle pulse. Counting from the clock edge that samples start, done goes high after the 37th edge. The results stay unchanged until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a read-and-search run (idle only) |
| acc_cycles | input | 16 | Accumulate count placed in the control words |
| tbl_rd | output | 1 | Table read strobe |
| tbl_addr | output | 4 | Table address, oscillator*4 + bias |
| tbl_data | input | 32 | Table read data, valid one cycle after the strobe |
| done | output | 1 | One-cycle pulse at the end of the search |
| bias_word | output | 6 | Packed chosen biases |
| best_total | output | 34 | Winning summed score |
| cell_scores | output | 96 | Per-oscillator score of the winning assignment |
| short_entropy | output | 1 | Best total below the minimum |
| ctl_words | output | 88 | Four control words, word n at bits [22n+21:22n] |

## Verification
The embedded properties assume that the table responds to each strobe with data on the following cycle. They also assume that start is raised only while the block is idle, so a run is never restarted partway through its read or search phase. The stimulus meets both conditions. A registered table model answers every strobe exactly one cycle later. The driver pulses start only after the previous done has been seen and the held results have been checked. Tables include all-zero entries, uniform ties, sums one below and exactly at the threshold, conflicting preferences for one bias, all-ones scores and random contents.

// File: rtl/osc_bias_selector.sv
module osc_bias_selector #(
  parameter int          SCORE_W   = 32,
  parameter int          CNT_W     = 16,
  parameter logic [63:0] MIN_TOTAL = 64'd150000000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CNT_W-1:0]     acc_cycles,
  output logic                 tbl_rd,
  output logic [3:0]           tbl_addr,
  input  logic [SCORE_W-1:0]   tbl_data,
  output logic                 done,
  output logic [5:0]           bias_word,
  output logic [SCORE_W+1:0]   best_total,
  output logic [3*SCORE_W-1:0] cell_scores,
  output logic                 short_entropy,
  output logic [4*(CNT_W+6)-1:0] ctl_words
);
  localparam int NOSC  = 3;
  localparam int NENT  = 12;
  localparam int NCAND = 24;
  localparam int SUM_W = SCORE_W + 2;
  localparam int CW_W  = CNT_W + 6;
  localparam logic [SUM_W-1:0] MIN_T  = MIN_TOTAL[SUM_W-1:0];
  localparam logic [5:0]       DEF_BW = 6'b10_01_00;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SRCH} st_t;
  st_t st;
  logic [4:0] cnt;
  logic       rd_q;
  logic [3:0] cap_a;
  logic [SCORE_W-1:0] tbl [NENT];

  function automatic logic [5:0] perm(input logic [4:0] idx);
    logic [1:0] b0, b1, b2;
    int k1, k2, j;
    b0 = 2'(idx / 5'd6);
    k1 = int'(idx % 5'd6) / 2;
    k2 = int'(idx % 5'd6) % 2;
    b1 = '0;
    b2 = '0;
    j  = 0;
    for (int v = 0; v < 4; v++)
      if (2'(v) != b0) begin
        if (j == k1) b1 = 2'(v);
        j++;
      end
    j = 0;
    for (int v = 0; v < 4; v++)
      if (2'(v) != b0 && 2'(v) != b1) begin
        if (j == k2) b2 = 2'(v);
        j++;
      end
    return {b2, b1, b0};
  endfunction

  logic [5:0]         cand;
  logic [SCORE_W-1:0] s0, s1, s2;
  logic [SUM_W-1:0]   cand_sum;

  assign cand     = perm(cnt);
  assign s0       = tbl[{2'd0, cand[1:0]}];
  assign s1       = tbl[{2'd1, cand[3:2]}];
  assign s2       = tbl[{2'd2, cand[5:4]}];
  assign cand_sum = SUM_W'(s0) + SUM_W'(s1) + SUM_W'(s2);

  assign tbl_rd   = (st == S_LOAD) && (cnt < 5'(NENT));
  assign tbl_addr = cnt[3:0];

  always_ff @(posedge clk) begin
    if (rd_q) tbl[cap_a] <= tbl_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      rd_q        <= 1'b0;
      cap_a       <= '0;
      done        <= 1'b0;
      bias_word   <= DEF_BW;
      best_total  <= '0;
      cell_scores <= '0;
    end else begin
      done  <= 1'b0;
      rd_q  <= tbl_rd;
      cap_a <= tbl_addr;
      case (st)
        S_IDLE: if (start) begin
          st          <= S_LOAD;
          cnt         <= '0;
          bias_word   <= DEF_BW;
          best_total  <= '0;
          cell_scores <= '0;
        end
        S_LOAD: begin
          if (cnt == 5'(NENT)) begin
            st  <= S_SRCH;
            cnt <= '0;
          end else begin
            cnt <= cnt + 5'd1;
          end
        end
        S_SRCH: begin
          if (cand_sum > best_total) begin
            best_total  <= cand_sum;
            bias_word   <= cand;
            cell_scores <= {s2, s1, s0};
          end
          if (cnt == 5'(NCAND - 1)) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            cnt <= cnt + 5'd1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign short_entropy = best_total < MIN_T;

  for (genvar n = 0; n < NOSC; n++) begin : g_cw
    assign ctl_words[n*CW_W +: CW_W] = {acc_cycles, 1'b1, bias_word[2*n +: 2], 3'(1 << n)};
  end
  assign ctl_words[3*CW_W +: CW_W] = {acc_cycles, 1'b1, 2'b00, 3'b111};

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r3_distinct_bias: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bias_word[1:0] != bias_word[3:2] && bias_word[1:0] != bias_word[5:4]
              && bias_word[3:2] != bias_word[5:4]));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> best_total == SUM_W'(cell_scores[0 +: SCORE_W]) + SUM_W'(cell_scores[SCORE_W +: SCORE_W])
                         + SUM_W'(cell_scores[2*SCORE_W +: SCORE_W]));

  a_r5_best_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SRCH) |=> best_total >= $past(best_total));

  a_r2_read_order: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_rd && $past(tbl_rd)) |-> tbl_addr == $past(tbl_addr) + 4'd1);
endmodule

// File: tb/osc_bias_selector_tb.sv
module osc_bias_selector_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [15:0]  acc_cycles = '0;
  logic         tbl_rd;
  logic [3:0]   tbl_addr;
  logic [31:0]  tbl_data = '0;
  logic         done;
  logic [5:0]   bias_word;
  logic [33:0]  best_total;
  logic [95:0]  cell_scores;
  logic         short_entropy;
  logic [87:0]  ctl_words;

  always #10 clk = ~clk;

  osc_bias_selector dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .acc_cycles(acc_cycles),
    .tbl_rd(tbl_rd), .tbl_addr(tbl_addr), .tbl_data(tbl_data), .done(done),
    .bias_word(bias_word), .best_total(best_total), .cell_scores(cell_scores),
    .short_entropy(short_entropy), .ctl_words(ctl_words));

  logic [31:0] mem [12];
  always @(posedge clk) if (tbl_rd) tbl_data <= mem[tbl_addr];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [5:0]  bw;
    logic [33:0] tot;
    logic [95:0] cells;
    bit          low;
    logic [15:0] acc;
    int          start_cyc;
  } exp_t;
  exp_t q[$];

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(logic [15:0] acc);
    exp_t e;
    e.bw = 6'h24; e.tot = '0; e.cells = '0; e.acc = acc; e.start_cyc = 0;
    for (int b0 = 0; b0 < 4; b0++)
      for (int b1 = 0; b1 < 4; b1++)
        for (int b2 = 0; b2 < 4; b2++) begin
          logic [33:0] t;
          if (b0 == b1 || b0 == b2 || b1 == b2) continue;
          t = 34'(mem[b0]) + 34'(mem[4+b1]) + 34'(mem[8+b2]);
          if (t > e.tot) begin
            e.tot = t;
            e.bw = {2'(b2), 2'(b1), 2'(b0)};
            e.cells = {mem[8+b2], mem[4+b1], mem[b0]};
          end
        end
    e.low = (e.tot < 34'd150000000);
    return e;
  endfunction

  task automatic run_case(logic [15:0] acc);
    exp_t e;
    e = model(acc);
    @(negedge clk);
    acc_cycles = acc;
    start = 1'b1;
    e.start_cyc = cyc + 1;
    q.push_back(e);
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(!done, "R10", "done width", 128'(done), 128'(0));
    repeat (3) @(negedge clk);
    chk(bias_word == e.bw && best_total == e.tot, "R10", "results held",
        128'({bias_word, best_total}), 128'({e.bw, e.tot}));
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (done) begin
        if (q.size() == 0) begin
          chk(0, "R10", "unexpected done", 128'(1), 128'(0));
        end else begin
          e = q.pop_front();
          chk(cyc - e.start_cyc == 37, "R10", "done latency", 128'(cyc - e.start_cyc), 128'(37));
          chk(bias_word == e.bw, "R3 R4 R5", "bias word", 128'(bias_word), 128'(e.bw));
          chk(best_total == e.tot, "R6 R7", "best total", 128'(best_total), 128'(e.tot));
          chk(cell_scores == e.cells, "R6", "cell scores", 128'(cell_scores), 128'(e.cells));
          chk(short_entropy == e.low, "R8", "short flag", 128'(short_entropy), 128'(e.low));
          for (int n = 0; n < 4; n++) begin
            logic [21:0] w;
            w = (n < 3) ? {e.acc, 1'b1, e.bw[2*n +: 2], 3'(1 << n)} : {e.acc, 1'b1, 2'b00, 3'b111};
            chk(ctl_words[22*n +: 22] == w, "R9", "control word", 128'(ctl_words[22*n +: 22]), 128'(w));
          end
        end
      end
    end
  end

  bit seen_rd = 0;
  int rd_next = 0;
  initial begin : read_mon
    forever begin
      @(negedge clk);
      if (tbl_rd && !finished) begin
        chk(32'(tbl_addr) == rd_next, "R2", "read address", 128'(tbl_addr), 128'(rd_next));
        rd_next = (rd_next + 1) % 12;
      end
    end
  end

  task automatic fill(input logic [31:0] v);
    for (int i = 0; i < 12; i++) mem[i] = v;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin : driver
    fill('0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bias_word == 6'h24, "R1", "reset bias", 128'(bias_word), 128'(6'h24));
    chk(best_total == 0 && cell_scores == 0, "R1", "reset totals", 128'(best_total), 128'(0));
    chk(!done && short_entropy, "R1", "reset flags", 128'({done, short_entropy}), 128'(2'b01));

    fill('0); run_case(16'h0001);                           // R5 all zero keeps default
    fill(32'd50000000); run_case(16'h1234);                 // R4 ties, R8 equal threshold
    fill(32'd50000000);
    for (int b = 0; b < 4; b++) mem[b] = 32'd49999999;      // R8 one below threshold
    run_case(16'hBEEF);
    fill(32'd1); mem[3] = 32'd100; mem[7] = 32'd90; mem[11] = 32'd80;
    run_case(16'h00FF);                                     // R3 conflicting preference
    fill(32'd5); mem[1] = 32'd9; mem[4] = 32'd9; mem[6] = 32'd4; mem[9] = 32'd4;
    run_case(16'h8000);                                     // R4 tie among later candidates
    fill(32'hFFFF_FFFF); run_case(16'hFFFF);                // R7 widest sum
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < 12; i++) mem[i] = $urandom_range(32'd90000000, 32'd0);
      run_case(16'($urandom));
    end
    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R10", "outstanding results", 128'(q.size()), 128'(0));
    summary();
  end
endmodule